// File: doc/BRIEF.md
# Self-configuring serial code register for a current-output DAC

This block keeps the digital setting of a 256-step current-sink DAC and lets a host change that setting over whichever of three serial schemes it happens to use. After reset the interface counts up on every clock pulse (increment-only pulse mode). The first low level seen on the chip-select pin switches it for good into a framed 3-wire shift mode. The first low level seen on the direction pin, while chip select is still high, switches it for good into an up/down pulse mode. Only a reset undoes either switch.

In the framed mode, a frame opens when chip select falls. A new code enters most significant bit first, one bit on each rising serial clock. During the same frame the setting that applied before the frame is returned on the data output, also most significant bit first. When chip select rises, the new code takes effect only if the frame held exactly as many clock pulses as the code has bits. In both pulse modes the code moves one step per rising serial clock and stops at the end of the range instead of wrapping.

All serial pins are taken as levels that are synchronous to the system clock `clk`. Edges on them are found by comparing against the level at the previous `clk` edge, so each level must be held for at least two `clk` cycles. The block has no analog part. It produces the code word, a data output with its separate drive enable, and a mode indicator.

Top module: `dac_code_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, the code becomes 0x80 (midscale), `mode` becomes 00 and `dout_oe` becomes 0.
- R2: `mode` reads 00 in increment-only pulse mode, 01 in up/down pulse mode and 10 in 3-wire mode. Value 11 never appears.
- R3: Once `mode` is 10, it keeps that value until reset. In that mode a low `updn` has no effect, and `sclk` pulses with `cs_n` high leave the code unchanged.
- R4: A low `updn` while `cs_n` is high in mode 00 sets `mode` to 01. A later high `updn` does not clear it. A later low `cs_n` still moves it to 10.
- R5: In mode 00 with `cs_n` high, each rising `sclk` adds one to the code.
- R6: In mode 01 with `cs_n` high, each rising `sclk` adds one when `updn` is 1 and subtracts one when `updn` is 0.
- R7: In the pulse modes the code holds at 0xFF when counting up and at 0x00 when counting down. It never wraps.
- R8: `dout_oe` goes to 1 after a falling `cs_n` and goes back to 0 after a rising `cs_n`. It is 0 whenever `cs_n` has been high for two `clk` edges, and it is never 1 outside mode 10.
- R9: In 3-wire mode `din` is sampled on each rising `sclk`, first bit = bit 7. On the rising `cs_n` the shifted byte becomes the code, provided exactly 8 rising `sclk` edges occurred in the frame.
- R10: A frame with fewer than 8 or more than 8 rising `sclk` edges leaves the code unchanged.
- R11: From the falling `cs_n` onward, `dout` shows bit 7 of the code that held before the frame. Each falling `sclk` then advances `dout` to the next lower bit.
- R12: Reset is synchronous and active low. It returns the block from any mode to mode 00 with code 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; its first low level selects 3-wire mode |
| sclk | input | 1 | Serial clock / count pulse input |
| din | input | 1 | Serial data in, most significant bit first |
| updn | input | 1 | Count direction (1 up, 0 down); its first low level selects up/down mode |
| code | output | 8 | Current DAC code |
| dout | output | 1 | Serial read-back of the previous code |
| dout_oe | output | 1 | Drive enable for `dout` (0 = high impedance) |
| mode | output | 2 | Active protocol: 00 increment-only, 01 up/down, 10 3-wire |

## Verification
The bench builds the block with the default code width of 8 bits. With that width, both saturation limits are reachable from midscale within about 130 pulses, so the up and down end stops can be driven directly. The 8-bit width also makes the frame length that the load rule accepts equal to 8, which lets a 7-pulse and a 9-pulse frame straddle it from both sides. Because each mode is sticky, every protocol scenario begins from its own reset. This also exercises reset out of each of the three modes.

// File: rtl/dac_code_pkg.sv
// Shared types for the serial DAC code register.
// Assumes nothing beyond a 2-bit mode field seen at the top ports.
package dac_code_pkg;

    typedef enum logic [1:0] {
        MODE_INC   = 2'b00,
        MODE_UPDN  = 2'b01,
        MODE_SHIFT = 2'b10
    } if_mode_e;

endpackage

// File: rtl/pin_edges.sv
// Finds rising and falling edges on N serial pins by comparing each pin with
// its level at the previous clk edge. Assumes the pins are synchronous to clk.
// During reset the history follows the pins, so no edge shows at release.
module pin_edges #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_pin
        // Keep last sampled level of pin i.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= pin_i[i];
            else        prev_q[i] <= pin_i[i];
        end

        // Edge flags for pin i.
        always_comb begin
            rise_o[i] = pin_i[i] & ~prev_q[i];
            fall_o[i] = ~pin_i[i] & prev_q[i];
        end
    end

endmodule

// File: rtl/mode_tracker.sv
// Sticky protocol selection: starts in increment-only mode, moves once to
// up/down mode on a low UP/DN (CS high) and once to 3-wire mode on a low CS.
// Only reset returns it to increment-only mode.
module mode_tracker
    import dac_code_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_n_i,
    input  logic     updn_i,
    output if_mode_e mode_o
);

    // Advance the mode one way only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= MODE_INC;
        end else if (mode_o != MODE_SHIFT && !cs_n_i) begin
            mode_o <= MODE_SHIFT;
        end else if (mode_o == MODE_INC && !updn_i) begin
            mode_o <= MODE_UPDN;
        end
    end

    assert_legal_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b11);

    assert_shift_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == MODE_SHIFT |=> mode_o == MODE_SHIFT);

    assert_updn_no_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == MODE_UPDN |=> mode_o != MODE_INC);

endmodule

// File: rtl/serial_shifter.sv
// 3-wire frame engine. A CS fall opens a frame and loads the current code for
// read-back; rising SCLK shifts DIN in MSB first, falling SCLK advances DOUT.
// On the CS rise a load is requested only if exactly W bits were clocked in.
module serial_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_fall_i,
    input  logic         cs_rise_i,
    input  logic         sclk_rise_i,
    input  logic         sclk_fall_i,
    input  logic         din_i,
    input  logic [W-1:0] code_i,
    output logic         dout_o,
    output logic         dout_oe_o,
    output logic         load_o,
    output logic [W-1:0] load_data_o
);

    localparam int CNT_W = $clog2(W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(W + 1);

    logic [W-1:0]     in_sh_q;
    logic [W-1:0]     out_sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic             active_q;

    // Frame open flag, which is also the DOUT drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n)         active_q <= 1'b0;
        else if (cs_fall_i) active_q <= 1'b1;
        else if (cs_rise_i) active_q <= 1'b0;
    end

    // Capture DIN on rising SCLK inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                      in_sh_q <= '0;
        else if (active_q && sclk_rise_i) in_sh_q <= {in_sh_q[W-2:0], din_i};
    end

    // Count rising SCLK edges per frame, holding above W to mark overrun.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          cnt_q <= '0;
        else if (cs_fall_i)                                  cnt_q <= '0;
        else if (active_q && sclk_rise_i && cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
    end

    // Read-back register: old code at frame start, shifted on falling SCLK.
    always_ff @(posedge clk) begin
        if (!rst_n)                       out_sh_q <= '0;
        else if (cs_fall_i)               out_sh_q <= code_i;
        else if (active_q && sclk_fall_i) out_sh_q <= {out_sh_q[W-2:0], 1'b0};
    end

    // Output drive and load request.
    always_comb begin
        dout_o      = out_sh_q[W-1];
        dout_oe_o   = active_q;
        load_o      = active_q && cs_rise_i && (cnt_q == CNT_FULL);
        load_data_o = in_sh_q;
    end

    assert_count_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall_i |=> cnt_q == '0);

    assert_oe_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise_i |=> !dout_oe_o);

endmodule

// File: rtl/code_store.sv
// Holds the DAC code. A frame load has priority; otherwise single-step
// increment or decrement with saturation at both ends. Reset gives midscale.
module code_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_data_i,
    input  logic         inc_i,
    input  logic         dec_i,
    output logic [W-1:0] code_o
);

    localparam logic [W-1:0] MID_CODE = W'(1) << (W - 1);
    localparam logic [W-1:0] TOP_CODE = '1;
    localparam logic [W-1:0] BOT_CODE = '0;

    // Update the code from a load or a saturating step.
    always_ff @(posedge clk) begin
        if (!rst_n)                             code_o <= MID_CODE;
        else if (load_i)                        code_o <= load_data_i;
        else if (inc_i && code_o != TOP_CODE)   code_o <= code_o + 1'b1;
        else if (dec_i && code_o != BOT_CODE)   code_o <= code_o - 1'b1;
    end

    assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (code_o == $past(code_o) || code_o == $past(code_o) + 1'b1
                     || code_o == $past(code_o) - 1'b1));

    assert_no_wrap_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o == TOP_CODE && !load_i) |=> code_o != BOT_CODE);

    assert_no_wrap_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o == BOT_CODE && !load_i) |=> code_o != TOP_CODE);

endmodule

// File: rtl/dac_code_ctrl.sv
// Top of the self-configuring DAC code register. Detects pin edges, tracks
// the sticky protocol mode, runs the 3-wire frame engine and steers pulse
// counts into the code store. Assumes pins are synchronous to clk and each
// level is held for at least two clk cycles.
module dac_code_ctrl
    import dac_code_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              updn,
    output logic [CODE_W-1:0] code,
    output logic              dout,
    output logic              dout_oe,
    output logic [1:0]        mode
);

    localparam int PIN_CS  = 0;
    localparam int PIN_CLK = 1;

    logic [1:0]        rise, fall;
    if_mode_e          mode_q;
    logic              load, inc, dec;
    logic [CODE_W-1:0] load_data;

    pin_edges #(.N(2)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({sclk, cs_n}),
        .rise_o (rise),
        .fall_o (fall)
    );

    mode_tracker u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n_i (cs_n),
        .updn_i (updn),
        .mode_o (mode_q)
    );

    serial_shifter #(.W(CODE_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_fall_i   (fall[PIN_CS]),
        .cs_rise_i   (rise[PIN_CS]),
        .sclk_rise_i (rise[PIN_CLK]),
        .sclk_fall_i (fall[PIN_CLK]),
        .din_i       (din),
        .code_i      (code),
        .dout_o      (dout),
        .dout_oe_o   (dout_oe),
        .load_o      (load),
        .load_data_o (load_data)
    );

    // Turn SCLK pulses into steps in the pulse modes (CS must stay high).
    always_comb begin
        inc = 1'b0;
        dec = 1'b0;
        if (cs_n && rise[PIN_CLK]) begin
            if (mode_q == MODE_INC)       inc = 1'b1;
            else if (mode_q == MODE_UPDN) begin
                inc = updn;
                dec = !updn;
            end
        end
    end

    code_store #(.W(CODE_W)) u_code (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .load_data_i (load_data),
        .inc_i       (inc),
        .dec_i       (dec),
        .code_o      (code)
    );

    // Mode indicator to the port.
    always_comb mode = mode_q;

    assert_oe_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !dout_oe);

    assert_oe_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> mode == MODE_SHIFT);

    assert_load_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (dout_oe && mode == MODE_SHIFT));

endmodule

// File: tb/test_dac_code_ctrl.sv
// Directed bench for dac_code_ctrl: one task per scenario, each checking itself.
module test_dac_code_ctrl;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b0;
    logic         din = 1'b0;
    logic         updn = 1'b1;
    logic [W-1:0] code;
    logic         dout;
    logic         dout_oe;
    logic [1:0]   mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dac_code_ctrl #(.CODE_W(W)) i_dac_code_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .din     (din),
        .updn    (updn),
        .code    (code),
        .dout    (dout),
        .dout_oe (dout_oe),
        .mode    (mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Let pin changes register, then return at a falling clk edge.
    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; updn = 1'b1; din = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic pulse();
        sclk = 1'b1; settle();
        sclk = 1'b0; settle();
    endtask

    // One 3-wire frame of nbits clocks; returns the read-back bits.
    task automatic frame(input logic [W-1:0] nv, input int nbits, output logic [W-1:0] rb);
        cs_n = 1'b0; settle();
        chk("R8 oe in frame", 32'(dout_oe), 32'd1);
        rb = '0;
        for (int i = 0; i < nbits; i++) begin
            if (i < W) begin
                rb[W-1-i] = dout;
                din = nv[W-1-i];
            end else begin
                din = 1'b0;
            end
            pulse();
        end
        cs_n = 1'b1; settle();
        chk("R8 oe after frame", 32'(dout_oe), 32'd0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 code", 32'(code), 32'h80);
        chk("R1 mode", 32'(mode), 32'h0);
        chk("R1 oe", 32'(dout_oe), 32'h0);
    endtask

    task automatic t_inc_only();
        do_reset();
        for (int i = 0; i < 5; i++) pulse();
        chk("R5 five increments", 32'(code), 32'h85);
        chk("R2 mode stays 00", 32'(mode), 32'h0);
        for (int i = 0; i < 125; i++) pulse();
        chk("R7 saturate at FF", 32'(code), 32'hFF);
        pulse();
        chk("R7 no wrap up", 32'(code), 32'hFF);
    endtask

    task automatic t_updn();
        do_reset();
        updn = 1'b0; settle();
        chk("R4 enter 01", 32'(mode), 32'h1);
        for (int i = 0; i < 3; i++) pulse();
        chk("R6 three downs", 32'(code), 32'h7D);
        updn = 1'b1; settle();
        chk("R4 01 sticky", 32'(mode), 32'h1);
        pulse(); pulse();
        chk("R6 two ups", 32'(code), 32'h7F);
        updn = 1'b0; settle();
        for (int i = 0; i < 130; i++) pulse();
        chk("R7 saturate at 00", 32'(code), 32'h00);
        cs_n = 1'b0; settle();
        chk("R4 CS low leaves 01", 32'(mode), 32'h2);
        cs_n = 1'b1; settle();
        do_reset();
        chk("R12 reset from 01 mode", 32'(mode), 32'h0);
        chk("R12 reset from 01 code", 32'(code), 32'h80);
    endtask

    task automatic t_three_wire();
        logic [W-1:0] rb;
        do_reset();
        chk("R8 idle oe", 32'(dout_oe), 32'h0);
        frame(8'hA5, 8, rb);
        chk("R11 readback midscale", 32'(rb), 32'h80);
        chk("R9 load A5", 32'(code), 32'hA5);
        chk("R2 mode 10", 32'(mode), 32'h2);
        frame(8'h3C, 8, rb);
        chk("R11 readback A5", 32'(rb), 32'hA5);
        chk("R9 load 3C", 32'(code), 32'h3C);
        frame(8'hFF, 7, rb);
        chk("R10 short frame", 32'(code), 32'h3C);
        frame(8'h00, 9, rb);
        chk("R10 long frame", 32'(code), 32'h3C);
        updn = 1'b0; settle();
        chk("R3 updn ignored", 32'(mode), 32'h2);
        for (int i = 0; i < 3; i++) pulse();
        chk("R3 pulses ignored", 32'(code), 32'h3C);
        chk("R8 oe with CS high", 32'(dout_oe), 32'h0);
        updn = 1'b1;
        do_reset();
        chk("R12 reset from 10 mode", 32'(mode), 32'h0);
        chk("R12 reset from 10 code", 32'(code), 32'h80);
    endtask

    initial begin
        t_reset();
        t_inc_only();
        t_updn();
        t_three_wire();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule